// File: doc/BRIEF.md
# Theta-Sliced Hough Line Accumulator

This block builds a partial Hough line histogram over a fixed, contiguous slice of angle bins. It accepts a raster-scanned image, one pixel per accepted beat on a valid/ready input. For every pixel it computes the quantized normal distance `rho` for each angle in its slice, turns that distance into a bin address, and adds the pixel value into a per-angle count memory. All slice angles are handled in parallel, so one pixel per cycle yields one histogram update per angle per cycle.

When the last pixel of the frame has been accepted, the block stops taking input. It waits for its update pipeline to empty and then streams every count out, one per cycle, angle by angle. Each location is cleared as it is read, so the next frame starts from an empty histogram. Several instances with different slice indices together cover the full angle set. Combining their outputs, and finding peaks, happens outside this block.

Top module: `hough_slice_acc`

## Requirements
- R1: Slice angle k (0 ≤ k < SLICE_ANGLES) has global index i = SLICE_IDX·SLICE_ANGLES + k and angle θ = −90° + 180°·i/THETA_RES. Its cosine and sine are signed 16-bit values with 15 fraction bits, rounded to nearest (ties away from zero) and saturated to [−32768, 32767], so +1.0 becomes 32767.
- R2: For the pixel at column x, row y, rho = (x·cosq + y·sinq)/2^15, rounded to nearest with ties away from zero and saturated to signed 16 bits. The bin is rho + RHO_MAX, where RHO_MAX = ceil(sqrt((ROWS−1)² + (COLS−1)²)), giving 2·RHO_MAX+1 bins per angle.
- R3: Pixels are taken row by row with x running fastest, starting at (0,0). A beat with `in_sof` high is placed at (0,0) whatever came before it.
- R4: Each update adds the pixel value itself, so a zero pixel leaves every count unchanged.
- R5: Updates to the same location on consecutive cycles all land: no increment is lost.
- R6: Counts are CNT_W bits wide and stop at 2^CNT_W−1 instead of wrapping.
- R7: Readout gives one count per cycle with `hist_valid` high. Angles come in ascending order and, within each angle, bins ascend. `hist_angle` and `hist_bin` label each count, and `hist_last` marks only the final one.
- R8: The first readout count appears on the fifth rising edge after the edge that accepts the last pixel of a frame.
- R9: `in_ready` is low from the cycle after the last pixel is accepted until the final readout count. It is high again in the cycle that shows `hist_last`.
- R10: Every location is zeroed as it is read out, so an all-zero frame that follows any frame reads back all zeros.
- R11: After reset, `hist_valid` is low and `in_ready` stays low for 2·RHO_MAX+1 cycles while the memories are cleared. It rises after that many rising edges.
- R12: While a frame is being received, `in_ready` stays high, and a pixel is accepted on every cycle that `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel beat present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_pix | input | PIX_W | Pixel value added to the counts |
| hist_valid | output | 1 | Readout count present |
| hist_angle | output | AW | Slice-local angle index of the count |
| hist_bin | output | BIN_W | Rho bin address of the count |
| hist_count | output | CNT_W | Accumulated, saturated count |
| hist_last | output | 1 | Final count of the readout |

## Verification
A pixel's update reaches memory on the third rising edge after it is accepted, and updates to the same bin one cycle apart are fed forward, so dense frames stress R5. The first readout count is due on the fifth edge after the last pixel is accepted, and the clear sweep after reset takes exactly 2·RHO_MAX+1 edges. The bench counts edges from each of these stimuli and samples on the falling edge just before and just after the expected change. Readout counts are compared one by one against a histogram the bench computes with real arithmetic and its own rounding, for zero, sparse, dense, mid-range and saturating frames, and for a frame restarted by `in_sof`.

// File: rtl/hough_pkg.sv
package hough_pkg;

  typedef enum logic [1:0] {ST_CLR, ST_ACC, ST_DRAIN, ST_READ} hough_state_e;

  // smallest r with r*r >= v
  function automatic int ceil_sqrt(input int v);
    int r;
    r = 0;
    while (r * r < v) r++;
    return r;
  endfunction

  // real -> Q1.15, round half away from zero, saturate
  function automatic logic signed [15:0] q15_coef(input real v);
    real s;
    int  r;
    s = v * 32768.0;
    if (s >= 0.0) r = $rtoi(s + 0.5);
    else          r = -$rtoi(-s + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  // x*c + y*s with Q15 coefficients, rounded to integer and saturated to 16 bits
  function automatic logic signed [15:0] rho_q(input int x, input int y,
                                               input logic signed [15:0] c,
                                               input logic signed [15:0] s);
    longint p;
    longint q;
    p = longint'(x) * longint'(c) + longint'(y) * longint'(s);
    if (p >= 0) q = (p + 64'sd16384) >>> 15;
    else        q = -((-p + 64'sd16384) >>> 15);
    if (q > 64'sd32767)  q = 64'sd32767;
    if (q < -64'sd32768) q = -64'sd32768;
    return 16'(q);
  endfunction

endpackage

// File: rtl/hough_rho.sv
module hough_rho import hough_pkg::*; #(
  parameter int THETA_RES = 128,
  parameter int ANGLE_IDX = 0,
  parameter int RHO_MAX   = 322,
  parameter int NBINS     = 645,
  parameter int XW        = 8,
  parameter int YW        = 8,
  parameter int BIN_W     = 10
) (
  input  logic [XW-1:0]    x,
  input  logic [YW-1:0]    y,
  output logic [BIN_W-1:0] addr
);
  localparam real PI      = 3.14159265358979323846;
  localparam real ANG_RAD = (-90.0 + 180.0 * real'(ANGLE_IDX) / real'(THETA_RES)) * PI / 180.0;
  localparam logic signed [15:0] COS_Q = q15_coef($cos(ANG_RAD));
  localparam logic signed [15:0] SIN_Q = q15_coef($sin(ANG_RAD));

  logic signed [15:0] rho;
  int                 bin_full;

  always_comb begin
    rho      = rho_q(int'(x), int'(y), COS_Q, SIN_Q);
    bin_full = int'(rho) + RHO_MAX;
    if (bin_full < 0)           addr = '0;
    else if (bin_full >= NBINS) addr = BIN_W'(NBINS - 1);
    else                        addr = BIN_W'(bin_full);
  end
endmodule

// File: rtl/hough_bank.sv
module hough_bank #(
  parameter int NBINS = 645,
  parameter int BIN_W = 10,
  parameter int PIX_W = 1,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_v,
  input  logic [PIX_W-1:0] upd_pix,
  input  logic [BIN_W-1:0] upd_addr,
  input  logic             ro_en,
  input  logic [BIN_W-1:0] ro_bin,
  input  logic             zero_en,
  output logic             busy,
  output logic [CNT_W-1:0] rd_q
);
  logic [CNT_W-1:0] mem [NBINS];

  logic             s2_v, s3_v, lw_v;
  logic [BIN_W-1:0] s2_addr, s3_addr, lw_addr;
  logic [PIX_W-1:0] s2_pix, s3_pix;
  logic [CNT_W-1:0] lw_data;

  logic             fwd_hit;
  logic [CNT_W-1:0] base_val;
  logic [CNT_W:0]   sum_ext;
  logic [CNT_W-1:0] wr_sum;
  logic [BIN_W-1:0] raddr;

  always_comb begin
    raddr    = ro_en ? ro_bin : s2_addr;
    fwd_hit  = lw_v && (lw_addr == s3_addr);
    base_val = fwd_hit ? lw_data : rd_q;
    sum_ext  = {1'b0, base_val} + (CNT_W+1)'(s3_pix);
    wr_sum   = sum_ext[CNT_W] ? '1 : sum_ext[CNT_W-1:0];
    busy     = s2_v | s3_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s3_v    <= 1'b0;
      lw_v    <= 1'b0;
      s2_addr <= '0;
      s3_addr <= '0;
      lw_addr <= '0;
      s2_pix  <= '0;
      s3_pix  <= '0;
      lw_data <= '0;
    end else begin
      s2_v    <= upd_v;
      s2_addr <= upd_addr;
      s2_pix  <= upd_pix;
      s3_v    <= s2_v;
      s3_addr <= s2_addr;
      s3_pix  <= s2_pix;
      lw_v    <= s3_v;
      lw_addr <= s3_addr;
      lw_data <= wr_sum;
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[raddr];
    if (zero_en)   mem[ro_bin]  <= '0;
    else if (s3_v) mem[s3_addr] <= wr_sum;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s3_v |-> (wr_sum >= base_val));

  // R5
  fwd_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && $past(s3_v) && (s3_addr == $past(s3_addr))) |-> (base_val == $past(wr_sum)));

  // R2
  bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> (int'(s2_addr) < NBINS));
endmodule

// File: rtl/hough_ctrl.sv
module hough_ctrl import hough_pkg::*; #(
  parameter int ROWS  = 216,
  parameter int COLS  = 240,
  parameter int NA    = 4,
  parameter int NBINS = 645,
  parameter int XW    = 8,
  parameter int YW    = 8,
  parameter int AW    = 2,
  parameter int BIN_W = 10,
  parameter int PIX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             in_ready,
  input  logic             pipe_busy,
  output logic             s1_v,
  output logic [PIX_W-1:0] s1_pix,
  output logic [XW-1:0]    s1_x,
  output logic [YW-1:0]    s1_y,
  output logic             ro_en,
  output logic             zero_all,
  output logic             rd_en,
  output logic [AW-1:0]    ro_angle,
  output logic [BIN_W-1:0] ro_bin,
  output logic             hist_valid,
  output logic [AW-1:0]    hist_angle,
  output logic [BIN_W-1:0] hist_bin,
  output logic             hist_last
);
  hough_state_e     state;
  logic [XW-1:0]    x_q, cur_x;
  logic [YW-1:0]    y_q, cur_y;
  logic             accept, row_end, frame_end, bin_end, ang_end;

  always_comb begin
    in_ready  = (state == ST_ACC);
    accept    = in_valid && in_ready;
    cur_x     = in_sof ? '0 : x_q;
    cur_y     = in_sof ? '0 : y_q;
    row_end   = (cur_x == XW'(COLS - 1));
    frame_end = row_end && (cur_y == YW'(ROWS - 1));
    bin_end   = (ro_bin == BIN_W'(NBINS - 1));
    ang_end   = (ro_angle == AW'(NA - 1));
    zero_all  = (state == ST_CLR);
    rd_en     = (state == ST_READ);
    ro_en     = zero_all | rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_CLR;
      x_q        <= '0;
      y_q        <= '0;
      s1_v       <= 1'b0;
      s1_pix     <= '0;
      s1_x       <= '0;
      s1_y       <= '0;
      ro_angle   <= '0;
      ro_bin     <= '0;
      hist_valid <= 1'b0;
      hist_angle <= '0;
      hist_bin   <= '0;
      hist_last  <= 1'b0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_x   <= cur_x;
        s1_y   <= cur_y;
        s1_pix <= in_pix;
        if (frame_end) begin
          x_q <= '0;
          y_q <= '0;
        end else if (row_end) begin
          x_q <= '0;
          y_q <= cur_y + 1'b1;
        end else begin
          x_q <= cur_x + 1'b1;
          y_q <= cur_y;
        end
      end
      hist_valid <= rd_en;
      hist_angle <= ro_angle;
      hist_bin   <= ro_bin;
      hist_last  <= rd_en && bin_end && ang_end;
      case (state)
        ST_CLR: begin
          if (bin_end) begin
            ro_bin <= '0;
            state  <= ST_ACC;
          end else begin
            ro_bin <= ro_bin + 1'b1;
          end
        end
        ST_ACC: begin
          if (accept && frame_end) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!s1_v && !pipe_busy) state <= ST_READ;
        end
        default: begin
          if (bin_end) begin
            ro_bin <= '0;
            if (ang_end) begin
              ro_angle <= '0;
              state    <= ST_ACC;
            end else begin
              ro_angle <= ro_angle + 1'b1;
            end
          end else begin
            ro_bin <= ro_bin + 1'b1;
          end
        end
      endcase
    end
  end

  // R9
  in_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frame_end) |=> !in_ready);

  // R7
  ro_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_valid && !hist_last) |=> (hist_valid &&
      ((hist_bin == $past(hist_bin) + BIN_W'(1)) ||
       ((hist_bin == '0) && (hist_angle == $past(hist_angle) + AW'(1))))));
endmodule

// File: rtl/hough_slice_acc.sv
module hough_slice_acc import hough_pkg::*; #(
  parameter int ROWS         = 216,
  parameter int COLS         = 240,
  parameter int THETA_RES    = 128,
  parameter int SLICE_ANGLES = 4,
  parameter int SLICE_IDX    = 0,
  parameter int PIX_W        = 1,
  parameter int CNT_W        = 16,
  localparam int RHO_MAX = ceil_sqrt((ROWS-1)*(ROWS-1) + (COLS-1)*(COLS-1)),
  localparam int NBINS   = 2 * RHO_MAX + 1,
  localparam int BIN_W   = $clog2(NBINS),
  localparam int XW      = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int YW      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AW      = (SLICE_ANGLES > 1) ? $clog2(SLICE_ANGLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             hist_valid,
  output logic [AW-1:0]    hist_angle,
  output logic [BIN_W-1:0] hist_bin,
  output logic [CNT_W-1:0] hist_count,
  output logic             hist_last
);
  logic                    s1_v;
  logic [PIX_W-1:0]        s1_pix;
  logic [XW-1:0]           s1_x;
  logic [YW-1:0]           s1_y;
  logic                    ro_en, zero_all, rd_en;
  logic [AW-1:0]           ro_angle;
  logic [BIN_W-1:0]        ro_bin;
  logic [SLICE_ANGLES-1:0] bank_busy;
  logic [BIN_W-1:0]        rho_addr [SLICE_ANGLES];
  logic [CNT_W-1:0]        bank_q   [SLICE_ANGLES];

  hough_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .NA(SLICE_ANGLES), .NBINS(NBINS),
    .XW(XW), .YW(YW), .AW(AW), .BIN_W(BIN_W), .PIX_W(PIX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix), .in_ready(in_ready),
    .pipe_busy(|bank_busy),
    .s1_v(s1_v), .s1_pix(s1_pix), .s1_x(s1_x), .s1_y(s1_y),
    .ro_en(ro_en), .zero_all(zero_all), .rd_en(rd_en),
    .ro_angle(ro_angle), .ro_bin(ro_bin),
    .hist_valid(hist_valid), .hist_angle(hist_angle), .hist_bin(hist_bin),
    .hist_last(hist_last)
  );

  for (genvar g = 0; g < SLICE_ANGLES; g++) begin : g_angle
    hough_rho #(
      .THETA_RES(THETA_RES), .ANGLE_IDX(SLICE_IDX * SLICE_ANGLES + g),
      .RHO_MAX(RHO_MAX), .NBINS(NBINS), .XW(XW), .YW(YW), .BIN_W(BIN_W)
    ) u_rho (
      .x(s1_x), .y(s1_y), .addr(rho_addr[g])
    );

    hough_bank #(
      .NBINS(NBINS), .BIN_W(BIN_W), .PIX_W(PIX_W), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .upd_v(s1_v), .upd_pix(s1_pix), .upd_addr(rho_addr[g]),
      .ro_en(ro_en), .ro_bin(ro_bin),
      .zero_en(zero_all || (rd_en && (ro_angle == AW'(g)))),
      .busy(bank_busy[g]), .rd_q(bank_q[g])
    );
  end

  assign hist_count = bank_q[hist_angle];

  // R9
  input_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_valid && !hist_last) |-> !in_ready);
endmodule

// File: tb/test_hough_slice_acc.sv
module test_hough_slice_acc;
  localparam int CLK_PERIOD = 10;
  localparam int R  = 6;
  localparam int C  = 8;
  localparam int TR = 12;
  localparam int NA = 4;
  localparam int SL = 1;
  localparam int PW = 8;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic       in_ready, hist_valid, hist_last;
  logic [1:0] hist_angle;
  logic [4:0] hist_bin;
  logic [9:0] hist_count;

  int checks = 0, fails = 0;
  int rm, nb;
  int cq [NA];
  int sq [NA];
  int exp_h [NA][64];
  int ro_idx = 0, frames_seen = 0;
  string cur_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  hough_slice_acc #(
    .ROWS(R), .COLS(C), .THETA_RES(TR), .SLICE_ANGLES(NA), .SLICE_IDX(SL),
    .PIX_W(PW), .CNT_W(CW)
  ) i_hough_slice_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .hist_valid(hist_valid),
    .hist_angle(hist_angle), .hist_bin(hist_bin), .hist_count(hist_count),
    .hist_last(hist_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int round_away(input real r);
    if (r >= 0.0) return $rtoi($floor(r + 0.5));
    return -$rtoi($floor(-r + 0.5));
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int bench_bin(input int x, input int y, input int k);
    real r;
    r = real'(x * cq[k] + y * sq[k]) / 32768.0;
    return clamp16(round_away(r)) + rm;
  endfunction

  function automatic int pix_of(input int kind, input int x, input int y, input int seed);
    case (kind)
      1: return (x == 0 && y == 5) ? 7 : ((x == 7 && y == 5) ? 3 : 0);
      2: return ((x + 2 * y + seed) % 3 == 0) ? 1 : 0;
      3: return 255;
      4: return (x * 37 + y * 91 + seed * 11) % 256;
      default: return 0;
    endcase
  endfunction

  task automatic model_add(input int x, input int y, input int p);
    for (int k = 0; k < NA; k++) begin
      int b;
      b = bench_bin(x, y, k);
      exp_h[k][b] = exp_h[k][b] + p;
      if (exp_h[k][b] > (1 << CW) - 1) exp_h[k][b] = (1 << CW) - 1;
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < NA; k++)
      for (int b = 0; b < 64; b++) exp_h[k][b] = 0;
  endtask

  task automatic send_partial(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_pix = 8'(p);
      model_add(i, 0, p);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
  endtask

  task automatic send_frame(input int kind, input int seed, input string req);
    int target;
    cur_req = req;
    target = frames_seen + 1;
    for (int y = 0; y < R; y++) begin
      for (int x = 0; x < C; x++) begin
        int p;
        @(negedge clk);
        // R12: ready must stay high throughout the frame
        check(in_ready == 1'b1, "R12 ready during frame", int'(in_ready), 1);
        while (!in_ready) @(negedge clk);
        p = pix_of(kind, x, y, seed);
        in_valid = 1'b1;
        in_sof = (x == 0 && y == 0);
        in_pix = 8'(p);
        model_add(x, y, p);
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    // R9: held off right after the last pixel
    check(in_ready == 1'b0, "R9 ready after last pixel", int'(in_ready), 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: nothing yet after four edges
    check(hist_valid == 1'b0, "R8 readout too early", int'(hist_valid), 0);
    @(posedge clk);
    @(negedge clk);
    // R8: first count on the fifth edge
    check(hist_valid == 1'b1, "R8 first readout count", int'(hist_valid), 1);
    wait (frames_seen == target);
    @(negedge clk);
    // R9: input accepted again after readout
    check(in_ready == 1'b1, "R9 ready after readout", int'(in_ready), 1);
    clear_model();
  endtask

  always @(negedge clk) begin
    if (rst_n && hist_valid) begin
      int ea, eb;
      ea = ro_idx / nb;
      eb = ro_idx % nb;
      check(int'(hist_angle) == ea, "R7 angle order", int'(hist_angle), ea);
      check(int'(hist_bin) == eb, "R7 bin order", int'(hist_bin), eb);
      check(int'(hist_count) == exp_h[ea][eb], {cur_req, " count"},
            int'(hist_count), exp_h[ea][eb]);
      if (ro_idx == NA * nb - 1) begin
        check(hist_last == 1'b1, "R7 last flag", int'(hist_last), 1);
        check(in_ready == 1'b1, "R9 ready with last", int'(in_ready), 1);
        ro_idx = 0;
        frames_seen++;
      end else begin
        check(hist_last == 1'b0, "R7 early last flag", int'(hist_last), 0);
        check(in_ready == 1'b0, "R9 ready during readout", int'(in_ready), 0);
        ro_idx++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frames_seen, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rm = $rtoi($ceil($sqrt(real'((R-1)*(R-1) + (C-1)*(C-1)))));
    nb = 2 * rm + 1;
    for (int k = 0; k < NA; k++) begin
      real a;
      a = (-90.0 + 180.0 * real'(SL * NA + k) / real'(TR)) * 3.14159265358979323846 / 180.0;
      cq[k] = clamp16(round_away($cos(a) * 32768.0));
      sq[k] = clamp16(round_away($sin(a) * 32768.0));
    end
    clear_model();

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check(in_ready == 1'b0, "R11 ready after reset", int'(in_ready), 0);
    check(hist_valid == 1'b0, "R11 hist_valid after reset", int'(hist_valid), 0);
    repeat (nb - 1) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R11 ready during clear", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready after clear", int'(in_ready), 1);

    send_frame(0, 0, "R10 R4 zero frame");
    send_frame(1, 0, "R1 R2 R4 sparse");
    send_frame(2, 1, "R3 R5 dense binary");
    send_frame(4, 3, "R5 R6 mixed values");
    send_frame(3, 0, "R6 saturating");
    send_partial(5, 200);
    send_frame(2, 2, "R3 sof restart");
    send_frame(0, 0, "R10 cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule